// File: doc/BRIEF.md
# Bridge PWM Output Steering

This block turns one pulse-width modulated waveform into the drive for four output pins, A, B, C and D, arranged for a single load, a complementary half-bridge or an H-bridge that runs in either direction. An external free-running timer supplies its count and a one-cycle pulse on the last count of each period. The block compares that count against a 10-bit duty value. The duty value is loaded only at the period boundary, so a write in the middle of a period cannot cut a pulse short.

A 2-bit steering code chooses the arrangement. In half-bridge use the two outputs get a programmable dead time before either one turns on. Two polarity bits, one for the A/C pair and one for the B/D pair, let each pair be active-high or active-low. An enable mask marks the pins that the block drives. Pins that the block does not drive are handed back with their enable low and their drive value at 0.

Top module: `bpwm_bridge`

## Requirements
- R1: While reset is asserted, every bit of `pin_drv` and `pin_oe` is 0.
- R2: The block drives pins only when `mode[3:2]` is 2'b11. For any other value of those bits, `pin_oe` and `pin_drv` are both 4'b0000.
- R3: The duty value is the 10-bit word {`duty_msb`,`duty_lsb`}, with `duty_lsb` as the two least significant bits. The internal PWM level is high while the timer count sampled at a clock edge is below the latched duty. The pins show that level one clock edge later. A duty of 0 gives no high cycles, and a duty at or above the period length gives a level that stays high.
- R4: The latched duty takes {`duty_msb`,`duty_lsb`} at the clock edge where `period_match` is high and keeps its value at every other edge. A duty change in the middle of a period does not alter that period's pulse.
- R5: Steering 2'b00 (single output): A is modulated, `pin_oe` is 4'b0001, and the drive of B, C and D is 0.
- R6: Steering 2'b01 (forward bridge): D is modulated, A is active, B and C are inactive, and `pin_oe` is 4'b1111.
- R7: Steering 2'b10 (half bridge): A follows the PWM level, B follows its complement, `pin_oe` is 4'b0011, and C and D are released.
- R8: In half-bridge use, A turns active only after the PWM level has been high for `dead_cnt` cycles, and B turns active only after the level has been low for `dead_cnt` cycles. A and B are never active in the same cycle.
- R9: Steering 2'b11 (reverse bridge): B is modulated, C is active, A and D are inactive, and `pin_oe` is 4'b1111.
- R10: When `mode[1]` is 1, A and C are active-low. When `mode[0]` is 1, B and D are active-low. Active and inactive levels are decided first, and the inversion is applied after that. Released pins stay at 0 whatever the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_cnt | input | CNT_W (10) | Count of the external PWM timer |
| period_match | input | 1 | High for one cycle on the last count of a period |
| duty_msb | input | CNT_W-2 (8) | Upper bits of the duty value |
| duty_lsb | input | 2 | Two least significant bits of the duty value |
| mode | input | 4 | [3:2] = 2'b11 enables PWM; [1] inverts A/C; [0] inverts B/D |
| steer | input | 2 | Output arrangement: 00 single, 01 forward, 10 half, 11 reverse |
| dead_cnt | input | DB_W (6) | Dead time in clock cycles for half-bridge use |
| pin_drv | output | 4 | Drive values, bit 0 = A through bit 3 = D |
| pin_oe | output | 4 | Pins owned by the block, same bit order |

## Verification
The assertions assume that `period_match` is a single-cycle pulse on the timer's last count. They also assume that `mode` and `steer` settle between clock edges, because the checker compares the registered pins against the control values sampled one edge earlier. The checker holds back the pin checks until one edge after reset has passed, so the values present during reset never reach them. The bench drives every input on the falling edge and counts its own timer from 0 to 39, raising `period_match` only on count 39. It changes the duty value and the steering only between edges, and one duty change is placed deliberately in the middle of a period.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

    typedef enum logic [1:0] {
        STEER_SINGLE = 2'b00,
        STEER_FWD    = 2'b01,
        STEER_HALF   = 2'b10,
        STEER_REV    = 2'b11
    } steer_e;

    localparam int NUM_PINS = 4;
    localparam int PIN_A    = 0;
    localparam int PIN_B    = 1;
    localparam int PIN_C    = 2;
    localparam int PIN_D    = 3;

    typedef struct packed {
        logic [NUM_PINS-1:0] drv;
        logic [NUM_PINS-1:0] oe;
    } pins_t;

endpackage

// File: rtl/bpwm_duty_core.sv
module bpwm_duty_core #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic             period_match,
    input  logic [CNT_W-1:0] duty_new,
    output logic [CNT_W-1:0] duty_lat,
    output logic             pwm_level
);

    typedef struct packed {
        logic [CNT_W-1:0] duty;
        logic             pwm;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwm = (tmr_cnt < st_q.duty);
        if (period_match) begin
            st_d.duty = duty_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_lat  = st_q.duty;
    assign pwm_level = st_q.pwm;

endmodule

// File: rtl/bpwm_deadband.sv
module bpwm_deadband #(
    parameter int DB_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_level,
    input  logic [DB_W-1:0] dead_cnt,
    output logic            act_a,
    output logic            act_b
);

    localparam logic [DB_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic            prev;
        logic [DB_W-1:0] cnt;
    } db_t;

    db_t             st_d, st_q;
    logic [DB_W-1:0] cnt_eff;
    logic            settled;

    always_comb begin
        cnt_eff = (pwm_level != st_q.prev) ? '0 : st_q.cnt;
        settled = (cnt_eff >= dead_cnt);
        act_a   = pwm_level && settled;
        act_b   = !pwm_level && settled;

        st_d      = st_q;
        st_d.prev = pwm_level;
        st_d.cnt  = (cnt_eff == CNT_MAX) ? CNT_MAX : cnt_eff + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bpwm_steer.sv
module bpwm_steer
    import bpwm_pkg::*;
(
    input  logic       pwm_level,
    input  logic       act_a,
    input  logic       act_b,
    input  logic [3:0] mode,
    input  logic [1:0] steer,
    output pins_t      pins
);

    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] own;
    logic                pwm_on;

    always_comb begin
        pwm_on = (mode[3:2] == 2'b11);
        lvl    = '0;
        own    = '0;
        if (pwm_on) begin
            case (steer_e'(steer))
                STEER_SINGLE: begin
                    own[PIN_A] = 1'b1;
                    lvl[PIN_A] = pwm_level;
                end
                STEER_FWD: begin
                    own        = '1;
                    lvl[PIN_A] = 1'b1;
                    lvl[PIN_D] = pwm_level;
                end
                STEER_HALF: begin
                    own[PIN_A] = 1'b1;
                    own[PIN_B] = 1'b1;
                    lvl[PIN_A] = act_a;
                    lvl[PIN_B] = act_b;
                end
                default: begin
                    own        = '1;
                    lvl[PIN_B] = pwm_level;
                    lvl[PIN_C] = 1'b1;
                end
            endcase
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int POL_BIT = (i % 2 == 0) ? 1 : 0;
        assign pins.oe[i]  = own[i];
        assign pins.drv[i] = own[i] & (lvl[i] ^ mode[POL_BIT]);
    end

endmodule

// File: rtl/bpwm_bridge.sv
module bpwm_bridge
    import bpwm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int DB_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic             period_match,
    input  logic [CNT_W-3:0] duty_msb,
    input  logic [1:0]       duty_lsb,
    input  logic [3:0]       mode,
    input  logic [1:0]       steer,
    input  logic [DB_W-1:0]  dead_cnt,
    output logic [3:0]       pin_drv,
    output logic [3:0]       pin_oe
);

    logic [CNT_W-1:0] duty_lat;
    logic             pwm_level;
    logic             act_a;
    logic             act_b;
    pins_t            pins_d, pins_q;

    bpwm_duty_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_cnt      (tmr_cnt),
        .period_match (period_match),
        .duty_new     ({duty_msb, duty_lsb}),
        .duty_lat     (duty_lat),
        .pwm_level    (pwm_level)
    );

    bpwm_deadband #(.DB_W(DB_W)) u_db (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_level (pwm_level),
        .dead_cnt  (dead_cnt),
        .act_a     (act_a),
        .act_b     (act_b)
    );

    bpwm_steer u_steer (
        .pwm_level (pwm_level),
        .act_a     (act_a),
        .act_b     (act_b),
        .mode      (mode),
        .steer     (steer),
        .pins      (pins_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign pin_drv = pins_q.drv;
    assign pin_oe  = pins_q.oe;

endmodule

// File: rtl/bpwm_chk.sv
module bpwm_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_match,
    input logic [CNT_W-3:0] duty_msb,
    input logic [1:0]       duty_lsb,
    input logic [3:0]       mode,
    input logic [1:0]       steer,
    input logic [3:0]       pin_drv,
    input logic [3:0]       pin_oe,
    input logic [CNT_W-1:0] duty_lat
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (pin_drv == 4'b0000 && pin_oe == 4'b0000));

    a_r2_released: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(mode[3:2]) != 2'b11 |-> (pin_oe == 4'b0000 && pin_drv == 4'b0000));

    a_r4_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !period_match |=> $stable(duty_lat));

    a_r4_duty_load: assert property (@(posedge clk) disable iff (!rst_n)
        period_match |=> duty_lat == $past({duty_msb, duty_lsb}));

    a_r5_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(mode[3:2]) == 2'b11 && $past(steer) == 2'b00
        |-> (pin_oe == 4'b0001 && pin_drv[3:1] == 3'b000));

    a_r6_fwd_static: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(mode[3:2]) == 2'b11 && $past(steer) == 2'b01
        |-> (pin_oe == 4'b1111 && pin_drv[0] == !$past(mode[1])
             && pin_drv[1] == $past(mode[0]) && pin_drv[2] == $past(mode[1])));

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(mode[3:2]) == 2'b11 && $past(steer) == 2'b10
        |-> !((pin_drv[0] ^ $past(mode[1])) && (pin_drv[1] ^ $past(mode[0]))));

    a_r7_half_mask: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(mode[3:2]) == 2'b11 && $past(steer) == 2'b10
        |-> (pin_oe == 4'b0011 && pin_drv[3:2] == 2'b00));

    a_r9_rev_static: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(mode[3:2]) == 2'b11 && $past(steer) == 2'b11
        |-> (pin_oe == 4'b1111 && pin_drv[2] == !$past(mode[1])
             && pin_drv[0] == $past(mode[1]) && pin_drv[3] == $past(mode[0])));

endmodule

bind bpwm_bridge bpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_match (period_match),
    .duty_msb     (duty_msb),
    .duty_lsb     (duty_lsb),
    .mode         (mode),
    .steer        (steer),
    .pin_drv      (pin_drv),
    .pin_oe       (pin_oe),
    .duty_lat     (duty_lat)
);

// File: tb/test_bpwm_bridge.sv
module test_bpwm_bridge;

    localparam int PER   = 40;
    localparam int CMAX  = 63;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] tmr_cnt = '0;
    logic       period_match = 1'b0;
    logic [7:0] duty_msb = '0;
    logic [1:0] duty_lsb = '0;
    logic [3:0] mode = '0;
    logic [1:0] steer = '0;
    logic [5:0] dead_cnt = '0;
    logic [3:0] pin_drv;
    logic [3:0] pin_oe;

    int checks = 0;
    int fails  = 0;
    int tmr    = 0;
    bit done   = 1'b0;

    int         m_duty = 0;
    int         m_pwm  = 0;
    int         m_cnt  = 0;
    logic [3:0] e_drv  = '0;
    logic [3:0] e_oe   = '0;

    always #5 clk = ~clk;

    bpwm_bridge i_bpwm_bridge (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_cnt      (tmr_cnt),
        .period_match (period_match),
        .duty_msb     (duty_msb),
        .duty_lsb     (duty_lsb),
        .mode         (mode),
        .steer        (steer),
        .dead_cnt     (dead_cnt),
        .pin_drv      (pin_drv),
        .pin_oe       (pin_oe)
    );

    // Behavioural reference: cycles since the PWM level last changed
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_duty = 0; m_pwm = 0; m_cnt = 0; e_drv = '0; e_oe = '0;
        end else begin
            int np;
            int nc;
            bit ac_low;
            bit bd_low;
            bit [3:0] act;
            ac_low = mode[1];
            bd_low = mode[0];
            act    = '0;
            e_oe   = '0;
            if (mode[3:2] == 2'b11) begin
                if (steer == 2'b00) begin
                    e_oe = 4'b0001; act[0] = (m_pwm == 1);
                end else if (steer == 2'b01) begin
                    e_oe = 4'b1111; act[0] = 1'b1; act[3] = (m_pwm == 1);
                end else if (steer == 2'b10) begin
                    e_oe = 4'b0011;
                    act[0] = (m_pwm == 1) && (m_cnt >= int'(dead_cnt));
                    act[1] = (m_pwm == 0) && (m_cnt >= int'(dead_cnt));
                end else begin
                    e_oe = 4'b1111; act[1] = (m_pwm == 1); act[2] = 1'b1;
                end
            end
            for (int i = 0; i < 4; i++) begin
                e_drv[i] = e_oe[i] ? (act[i] ^ ((i % 2 == 0) ? ac_low : bd_low)) : 1'b0;
            end
            np = (int'(tmr_cnt) < m_duty) ? 1 : 0;
            nc = (np != m_pwm) ? 0 : ((m_cnt >= CMAX) ? CMAX : m_cnt + 1);
            m_pwm = np;
            m_cnt = nc;
            if (period_match) m_duty = {duty_msb, duty_lsb};
        end
    end

    function automatic string tag_now();
        if (mode[3:2] != 2'b11) return "R2";
        case (steer)
            2'b00:   return "R5 R3 R10";
            2'b01:   return "R6 R10";
            2'b10:   return "R7 R8 R10";
            default: return "R9 R10";
        endcase
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // one clock: compare outputs to the model, then advance the timer
    task automatic step();
        @(negedge clk);
        check_eq(tag_now(), int'({pin_oe, pin_drv}), int'({e_oe, e_drv}));
        if (mode[3:2] == 2'b11 && steer == 2'b10) begin
            check_eq("R8 overlap", int'((pin_drv[0] ^ mode[1]) & (pin_drv[1] ^ mode[0])), 0);
        end
        tmr          = (tmr == PER - 1) ? 0 : tmr + 1;
        tmr_cnt      = 10'(tmr);
        period_match = (tmr == PER - 1);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_duty(input int d);
        duty_msb = 8'(d >> 2);
        duty_lsb = 2'(d);
    endtask

    task automatic align();
        while (tmr != 0) step();
    endtask

    task automatic count_hi(input int pin, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (pin_drv[pin] ^ ((pin % 2 == 0) ? mode[1] : mode[0])) hi++;
        end
    endtask

    initial begin
        int hi;
        int hb;
        repeat (3) @(negedge clk);
        check_eq("R1 drv", int'(pin_drv), 0);
        check_eq("R1 oe", int'(pin_oe), 0);
        mode = 4'b1111; steer = 2'b01;
        @(negedge clk);
        check_eq("R1 held", int'({pin_oe, pin_drv}), 0);
        mode = 4'b0000; steer = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: not a PWM mode, all pins released
        set_duty(23); steer = 2'b01; mode = 4'b1001;
        run(100);
        check_eq("R2 oe", int'(pin_oe), 0);

        // R3: single output, duty built from both parts
        mode = 4'b1100; steer = 2'b00;
        run(90); align();
        count_hi(0, PER, hi); check_eq("R3 duty 23", hi, 23);
        set_duty(0); run(90); align();
        count_hi(0, PER, hi); check_eq("R3 duty 0", hi, 0);
        set_duty(1023); run(90); align();
        count_hi(0, PER, hi); check_eq("R3 duty full", hi, PER);
        set_duty(2); run(90); align();
        count_hi(0, PER, hi); check_eq("R3 lsb only", hi, 2);

        // R4: change in the middle of a period has no effect on it
        set_duty(23); run(90); align();
        hi = 0;
        for (int i = 0; i < PER; i++) begin
            step();
            if (pin_drv[0]) hi++;
            if (i == 10) set_duty(3);
        end
        check_eq("R4 mid-period", hi, 23);
        run(60); align();
        count_hi(0, PER, hi); check_eq("R4 next period", hi, 3);

        // R10 with single output: released pins stay 0
        mode = 4'b1111; set_duty(17); run(90); align();
        count_hi(0, PER, hi); check_eq("R10 A inverted", hi, 17);
        check_eq("R10 released B-D", int'(pin_drv[3:1]), 0);

        // R7/R8: half bridge, no dead time then with dead time
        mode = 4'b1100; steer = 2'b10; set_duty(20); dead_cnt = 6'd0;
        run(90); align();
        count_hi(0, PER, hi); count_hi(1, PER, hb);
        check_eq("R7 A high", hi, 20); check_eq("R7 B high", hb, 20);
        dead_cnt = 6'd5; run(90); align();
        count_hi(0, PER, hi); count_hi(1, PER, hb);
        check_eq("R8 A high", hi, 15); check_eq("R8 B high", hb, 15);
        mode = 4'b1111; dead_cnt = 6'd3; run(120);
        mode = 4'b1110; dead_cnt = 6'd63; run(120);
        dead_cnt = 6'd0; set_duty(0); run(90);
        mode = 4'b1101; set_duty(1000); run(90);

        // R6: forward bridge, all polarities
        steer = 2'b01; set_duty(12);
        for (int p = 0; p < 4; p++) begin
            mode = 4'(12 + p); run(90);
        end
        align(); count_hi(3, PER, hi); check_eq("R6 D high", hi, 12);

        // R9: reverse bridge, all polarities
        steer = 2'b11; set_duty(30);
        for (int p = 0; p < 4; p++) begin
            mode = 4'(12 + p); run(90);
        end
        align(); count_hi(1, PER, hi); check_eq("R9 B high", hi, 30);

        // back to a non-PWM mode
        mode = 4'b0100; run(60);
        check_eq("R2 exit", int'({pin_oe, pin_drv}), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule